// File: doc/BRIEF.md
# Negacyclic Polynomial Multiplier with One Karatsuba Split

The block multiplies two polynomials of `N` coefficients each, with every coefficient taken modulo 2^13. It returns the product reduced modulo x^N + 1. The block does not use a full-size multiplier. It splits each operand into a low half and a high half and uses one half-size schoolbook kernel three times in sequence. The first call multiplies the two low halves. The second multiplies the two high halves. The third multiplies the two half-sums.

The results of the first two calls are registered. The third result is combined with them in the same cycle. Each half of each kernel product goes to fixed result positions with fixed signs. The upper half of the double-length product is then subtracted from the lower half, which is the negacyclic wrap.

To use the block, the host drives both operands and raises `start` while `busy` is low. Three cycles later `done` pulses for one cycle and `prod` holds the result. `prod` keeps that value until the next operation completes.

Top module: `karatsuba_negacyclic_mul`

## Requirements
- R1: After reset, `busy` and `done` are low and every coefficient of `prod` is zero.
- R2: When `start` is high while `busy` is low, the operands are captured at that clock edge and `busy` is high from the next cycle on.
- R3: `busy` stays high for exactly three cycles after an accepted start. `done` is high for exactly one cycle, in the first cycle after `busy` falls.
- R4: A `start` raised while `busy` is high has no effect. The running operation keeps its captured operands and its timing.
- R5: `prod` equals the product of the two operands modulo x^N + 1, with every coefficient reduced modulo 8192.
- R6: Coefficient i of each operand and of `prod` sits at bits [13*i+12 : 13*i]. Coefficient 0 is the constant term.
- R7: `prod` changes only in the cycle in which `done` is high, and otherwise holds its last value.
- R8: A product term whose exponent reaches N or more wraps to exponent minus N with its sign inverted. For example, x^(N-1) times x gives coefficient 0 equal to 8191 and all other coefficients equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiplication of `op_a` by `op_b` |
| op_a | input | N*13 | First operand, packed coefficients |
| op_b | input | N*13 | Second operand, packed coefficients |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when `prod` is updated |
| prod | output | N*13 | Negacyclic product, packed coefficients |

## Verification
The multiplier is exercised with several kinds of input, and each kind isolates a different part of the datapath:

- **Single monomials.** These show whether each half lands in the right slot and whether the wrap negates it.
- **Operands with all coefficients at 8191.** These stress the modulo-8192 truncation in the half-sums and in the kernel.
- **Operands with one half zero.** These separate the contributions of the low-half, high-half and sum products.
- **Random operand pairs.** These are compared against a direct schoolbook negacyclic product.

A start raised while busy and back-to-back operations check that captured operands are not disturbed and that the three-cycle timing does not change.

// File: rtl/karatsuba_negacyclic_mul.sv
module karatsuba_negacyclic_mul #(
  parameter int N = 16,
  parameter int W = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*W-1:0] op_a,
  input  logic [N*W-1:0] op_b,
  output logic           busy,
  output logic           done,
  output logic [N*W-1:0] prod
);
  localparam int H  = N / 2;
  localparam int VW = N * W;

  typedef enum logic [1:0] {IDLE, LOW, HIGH, MID} st_t;
  st_t st;

  logic [VW-1:0] a_q, b_q;
  logic [W-1:0]  ka [H];
  logic [W-1:0]  kb [H];
  logic [W-1:0]  kp [N];
  logic [W-1:0]  d  [N];
  logic [W-1:0]  e  [N];
  logic [W-1:0]  res [N];

  assign busy = (st != IDLE);

  for (genvar h = 0; h < H; h++) begin : g_pre
    logic [W-1:0] al, ah, bl, bh;
    assign al = a_q[h*W +: W];
    assign ah = a_q[(h+H)*W +: W];
    assign bl = b_q[h*W +: W];
    assign bh = b_q[(h+H)*W +: W];
    assign ka[h] = (st == LOW) ? al : (st == HIGH) ? ah : W'(al + ah);
    assign kb[h] = (st == LOW) ? bl : (st == HIGH) ? bh : W'(bl + bh);
  end

  always_comb begin
    for (int k = 0; k < N; k++) kp[k] = '0;
    for (int i = 0; i < H; i++)
      for (int j = 0; j < H; j++)
        kp[i+j] = W'(kp[i+j] + ka[i] * kb[j]);
  end

  for (genvar m = 0; m < H; m++) begin : g_post
    assign res[m]   = W'(d[m] - (kp[m+H] + e[m] - e[m+H] - d[m+H]));
    assign res[m+H] = W'(kp[m] + d[m+H] - e[m] - d[m] - e[m+H]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      a_q  <= '0;
      b_q  <= '0;
      done <= 1'b0;
      prod <= '0;
      for (int k = 0; k < N; k++) begin
        d[k] <= '0;
        e[k] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          a_q <= op_a;
          b_q <= op_b;
          st  <= LOW;
        end
        LOW: begin
          d  <= kp;
          st <= HIGH;
        end
        HIGH: begin
          e  <= kp;
          st <= MID;
        end
        default: begin
          for (int k = 0; k < N; k++) prod[k*W +: W] <= res[k];
          done <= 1'b1;
          st   <= IDLE;
        end
      endcase
    end
  end

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r3_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 (!busy && done));
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r4_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(b_q)));
  a_r7_prod_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(prod));
endmodule

// File: tb/sim_karatsuba_negacyclic_mul.sv
module sim_karatsuba_negacyclic_mul;
  localparam int N = 16;
  localparam int W = 13;

  logic clk = 0, rst_n = 0, start = 0;
  logic [N*W-1:0] op_a = '0, op_b = '0;
  logic busy, done;
  logic [N*W-1:0] prod;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  karatsuba_negacyclic_mul #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .prod(prod));

  function automatic logic [N*W-1:0] ref_mul(input logic [N*W-1:0] a, input logic [N*W-1:0] b);
    int acc [N];
    logic [N*W-1:0] r;
    for (int k = 0; k < N; k++) acc[k] = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int t;
        t = int'(a[i*W +: W]) * int'(b[j*W +: W]);
        if (i + j < N) acc[i+j] += t;
        else acc[i+j-N] -= t;
      end
    for (int k = 0; k < N; k++) r[k*W +: W] = W'(acc[k] & 8191);
    return r;
  endfunction

  task automatic chk(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [N*W-1:0] a, input logic [N*W-1:0] b);
    int cnt;
    @(negedge clk);
    op_a = a; op_b = b; start = 1;
    @(negedge clk);
    start = 0; op_a = '0; op_b = '0;
    chk({req, " R2 busy"}, N*W'(busy), N*W'(1));
    cnt = 1;
    while (!done && cnt < 10) begin
      @(negedge clk);
      cnt++;
    end
    chk({req, " R3 latency"}, N*W'(cnt), N*W'(4));
    chk({req, " R5 product"}, prod, ref_mul(a, b));
    @(negedge clk);
    chk({req, " R3 done pulse"}, N*W'({done, busy}), '0);
    chk({req, " R7 hold"}, prod, ref_mul(a, b));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset", {prod, busy, done} , '0);
  endtask

  task automatic t_wrap;
    logic [N*W-1:0] a = '0, b = '0, exp = '0;
    a[(N-1)*W +: W] = 1;
    b[1*W +: W] = 1;
    exp[0 +: W] = 8191;
    run("R8 R6 wrap", a, b);
    chk("R8 wrap coeff", prod, exp);
  endtask

  task automatic t_mono;
    logic [N*W-1:0] a = '0, b = '0, exp = '0;
    a[3*W +: W] = 5;
    b[4*W +: W] = 7;
    exp[7*W +: W] = 35;
    run("R6 monomial", a, b);
    chk("R6 position", prod, exp);
  endtask

  task automatic t_max;
    run("R5 all-max", {N{13'h1fff}}, {N{13'h1fff}});
  endtask

  task automatic t_halves;
    logic [N*W-1:0] a = '0, b = '0;
    for (int k = 0; k < N/2; k++) begin
      a[k*W +: W] = W'(k + 3);
      b[(k+N/2)*W +: W] = W'(2*k + 1);
    end
    run("R5 low-by-high", a, b);
    run("R5 high-by-low", b, a);
  endtask

  task automatic t_random;
    for (int t = 0; t < 20; t++) begin
      logic [N*W-1:0] a, b;
      for (int k = 0; k < N; k++) begin
        a[k*W +: W] = W'($urandom);
        b[k*W +: W] = W'($urandom);
      end
      run("R5 random", a, b);
    end
  endtask

  task automatic t_busy_start;
    logic [N*W-1:0] a, b, c;
    int cnt;
    for (int k = 0; k < N; k++) begin
      a[k*W +: W] = W'(k * 11 + 1);
      b[k*W +: W] = W'(8000 - k);
      c[k*W +: W] = W'(k);
    end
    @(negedge clk);
    op_a = a; op_b = b; start = 1;
    @(negedge clk);
    op_a = c; op_b = c;
    cnt = 1;
    while (!done && cnt < 10) begin
      @(negedge clk);
      cnt++;
    end
    start = 0;
    chk("R4 latency unchanged", N*W'(cnt), N*W'(4));
    chk("R4 operands kept", prod, ref_mul(a, b));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_mono();
    t_wrap();
    t_max();
    t_halves();
    t_random();
    t_busy_start();
    run("R5 back-to-back", {N{13'h0abc}}, {N{13'h1234}});
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule